// File: doc/BRIEF.md
# Chained Vector Multiply/Add Pipelines

Two fixed-latency integer vector units, one multiplying and one adding, operate element by element on a small register file of 64-element vectors. Each unit accepts one element pair per cycle. Each result is written back into the register file six cycles after its operands are read. A vector of n elements therefore occupies a unit for n + 5 cycles.

A scoreboard bit per register marks it as the target of an instruction in flight. With chaining enabled, a consumer may read element k of a busy register once the producer has written element k back. The two operations then overlap element by element. With chaining disabled, the consumer waits for the whole producer vector.

A single-cycle done pulse marks the writeback of the last element of the last active instruction. Vectors are loaded and read through a plain element port.

Top module: `vchain_top`

## Requirements
- R1: After reset, done_o is 0 and issue_ready_o is 1.
- R2: A multiply writes the low ELEM_W bits of the element product to every element of the destination. An add writes the low ELEM_W bits of the element sum.
- R3: For an instruction accepted at clock edge 0, element 0 of the destination changes at edge 6. An isolated 64-element instruction raises done_o at edge 69, which is n + 5.
- R4: With chain_en_i = 0, a multiply accepted at edge 0 followed by a dependent add accepted at edge 1 raises done_o at edge 138.
- R5: With chain_en_i = 1, the same dependent pair raises done_o at edge 75.
- R6: The chained pair computes d(k) = b(k)*c(k) + e(k) on every element. The product may feed either add operand.
- R7: done_o is high for exactly one cycle. It rises only when no instruction remains active, and it stays low while another instruction is still running.
- R8: issue_ready_o is 0 while the unit selected by issue_op_i (0 = multiply, 1 = add) is busy, or while the destination register is the target of an active instruction. While issue_ready_o is 0, no instruction is accepted.
- R9: A consumer reads element k of a register being written by the other unit only after that unit has written element k back.
- R10: A multiply and an independent add run concurrently. Accepted at edges 0 and 1, they raise done_o once, at edge 70.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| chain_en_i | input | 1 | 1 = chained element forwarding, 0 = wait for whole vector |
| ld_en_i | input | 1 | Element write strobe |
| ld_reg_i | input | $clog2(NREGS) | Element write register |
| ld_idx_i | input | $clog2(VLEN) | Element write index |
| ld_data_i | input | ELEM_W | Element write data |
| rd_reg_i | input | $clog2(NREGS) | Element read register |
| rd_idx_i | input | $clog2(VLEN) | Element read index |
| rd_data_o | output | ELEM_W | Element read data (combinational) |
| issue_valid_i | input | 1 | Instruction valid |
| issue_op_i | input | 1 | 0 = multiply, 1 = add |
| issue_dst_i | input | $clog2(NREGS) | Destination register |
| issue_src_a_i | input | $clog2(NREGS) | First source register |
| issue_src_b_i | input | $clog2(NREGS) | Second source register |
| issue_ready_o | output | 1 | Instruction accepted when high with valid |
| done_o | output | 1 | One-cycle pulse after last element of final instruction |

## Verification
The bench builds the default parameters: 16-bit elements, 64-element vectors, 8 registers and a pipeline depth of 6. These values make the completion edges 69, 70, 75 and 138 exact targets, and a behavioural model compares done_o against them on every clock. A probe on element 0 of the destination exposes the six-cycle writeback. Full readback of every destination element covers products that wrap past 16 bits.

// File: rtl/vchain_pkg.sv
package vchain_pkg;
  typedef enum logic {OP_MUL = 1'b0, OP_ADD = 1'b1} vop_e;
endpackage

// File: rtl/vchain_rf.sv
module vchain_rf #(
  parameter int ELEM_W = 16,
  parameter int NREGS  = 8,
  parameter int VLEN   = 64,
  parameter int NRD    = 5,
  parameter int NWR    = 3
) (
  input  logic                                 clk_i,
  input  logic [NWR-1:0]                       we_i,
  input  logic [NWR-1:0][$clog2(NREGS)-1:0]    wreg_i,
  input  logic [NWR-1:0][$clog2(VLEN)-1:0]     widx_i,
  input  logic [NWR-1:0][ELEM_W-1:0]           wdata_i,
  input  logic [NRD-1:0][$clog2(NREGS)-1:0]    rreg_i,
  input  logic [NRD-1:0][$clog2(VLEN)-1:0]     ridx_i,
  output logic [NRD-1:0][ELEM_W-1:0]           rdata_o
);
  logic [ELEM_W-1:0] mem [NREGS][VLEN];

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NWR; p++) begin
      if (we_i[p]) mem[wreg_i[p]][widx_i[p]] <= wdata_i[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NRD; p++) rdata_o[p] = mem[rreg_i[p]][ridx_i[p]];
  end
endmodule

// File: rtl/vchain_unit.sv
module vchain_unit import vchain_pkg::*; #(
  parameter int   ELEM_W = 16,
  parameter int   VLEN   = 64,
  parameter int   DEPTH  = 6,
  parameter int   NREGS  = 8,
  parameter vop_e OP     = OP_MUL
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [$clog2(NREGS)-1:0] dst_i,
  input  logic [$clog2(NREGS)-1:0] src_a_i,
  input  logic [$clog2(NREGS)-1:0] src_b_i,
  input  logic                     rd_ok_i,
  input  logic [ELEM_W-1:0]        opa_i,
  input  logic [ELEM_W-1:0]        opb_i,
  output logic                     act_o,
  output logic [$clog2(NREGS)-1:0] dst_o,
  output logic [$clog2(NREGS)-1:0] src_a_o,
  output logic [$clog2(NREGS)-1:0] src_b_o,
  output logic [$clog2(VLEN)-1:0]  rd_idx_o,
  output logic                     fire_o,
  output logic                     wb_en_o,
  output logic [$clog2(VLEN)-1:0]  wb_idx_o,
  output logic [ELEM_W-1:0]        wb_data_o,
  output logic [$clog2(VLEN+1)-1:0] wb_cnt_o,
  output logic                     last_o
);
  localparam int IW = $clog2(VLEN);
  localparam int CW = $clog2(VLEN+1);
  localparam int NS = DEPTH - 1;  // pipe regs; the RF write is the last stage

  logic [CW-1:0]     rd_cnt;
  logic [NS-1:0]     pv;
  logic [ELEM_W-1:0] pd [NS];
  logic [IW-1:0]     pi [NS];
  logic [ELEM_W-1:0] res;

  generate
    if (OP == OP_MUL) begin : g_mul
      assign res = opa_i * opb_i;
    end else begin : g_add
      assign res = opa_i + opb_i;
    end
  endgenerate

  assign fire_o    = act_o && (rd_cnt < CW'(VLEN)) && rd_ok_i;
  assign rd_idx_o  = rd_cnt[IW-1:0];
  assign wb_en_o   = pv[NS-1];
  assign wb_idx_o  = pi[NS-1];
  assign wb_data_o = pd[NS-1];
  assign last_o    = wb_en_o && (wb_idx_o == IW'(VLEN-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o    <= 1'b0;
      dst_o    <= '0;
      src_a_o  <= '0;
      src_b_o  <= '0;
      rd_cnt   <= '0;
      wb_cnt_o <= '0;
      pv       <= '0;
    end else begin
      pv[0] <= fire_o;
      for (int j = 1; j < NS; j++) pv[j] <= pv[j-1];
      if (start_i) begin
        act_o    <= 1'b1;
        dst_o    <= dst_i;
        src_a_o  <= src_a_i;
        src_b_o  <= src_b_i;
        rd_cnt   <= '0;
        wb_cnt_o <= '0;
      end else begin
        if (fire_o)  rd_cnt   <= rd_cnt + CW'(1);
        if (wb_en_o) wb_cnt_o <= wb_cnt_o + CW'(1);
        if (last_o)  act_o    <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i) begin
    pd[0] <= res;
    pi[0] <= rd_idx_o;
    for (int j = 1; j < NS; j++) begin
      pd[j] <= pd[j-1];
      pi[j] <= pi[j-1];
    end
  end
endmodule

// File: rtl/vchain_top.sv
module vchain_top import vchain_pkg::*; #(
  parameter int ELEM_W = 16,
  parameter int VLEN   = 64,
  parameter int NREGS  = 8,
  parameter int DEPTH  = 6
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     chain_en_i,
  input  logic                     ld_en_i,
  input  logic [$clog2(NREGS)-1:0] ld_reg_i,
  input  logic [$clog2(VLEN)-1:0]  ld_idx_i,
  input  logic [ELEM_W-1:0]        ld_data_i,
  input  logic [$clog2(NREGS)-1:0] rd_reg_i,
  input  logic [$clog2(VLEN)-1:0]  rd_idx_i,
  output logic [ELEM_W-1:0]        rd_data_o,
  input  logic                     issue_valid_i,
  input  logic                     issue_op_i,
  input  logic [$clog2(NREGS)-1:0] issue_dst_i,
  input  logic [$clog2(NREGS)-1:0] issue_src_a_i,
  input  logic [$clog2(NREGS)-1:0] issue_src_b_i,
  output logic                     issue_ready_o,
  output logic                     done_o
);
  localparam int RW = $clog2(NREGS);
  localparam int IW = $clog2(VLEN);
  localparam int CW = $clog2(VLEN+1);
  localparam int NU = 2;
  localparam int NRD = 2*NU + 1;
  localparam int NWR = NU + 1;

  logic [NU-1:0]              act, last, fire, wb_en, start, rd_ok;
  logic [NU-1:0][RW-1:0]      dst, src_a, src_b;
  logic [NU-1:0][IW-1:0]      idx, wb_idx;
  logic [NU-1:0][ELEM_W-1:0]  wb_data;
  logic [NU-1:0][CW-1:0]      wb_cnt;
  logic [NREGS-1:0]           sb;
  logic                       accept;

  logic [NWR-1:0]             rf_we;
  logic [NWR-1:0][RW-1:0]     rf_wreg;
  logic [NWR-1:0][IW-1:0]     rf_widx;
  logic [NWR-1:0][ELEM_W-1:0] rf_wdata;
  logic [NRD-1:0][RW-1:0]     rf_rreg;
  logic [NRD-1:0][IW-1:0]     rf_ridx;
  logic [NRD-1:0][ELEM_W-1:0] rf_rdata;

  assign issue_ready_o = !act[issue_op_i] && !sb[issue_dst_i];
  assign accept        = issue_valid_i && issue_ready_o;
  assign start         = {accept & issue_op_i, accept & ~issue_op_i};

  // external port has lowest write priority
  assign rf_we[0]    = ld_en_i;
  assign rf_wreg[0]  = ld_reg_i;
  assign rf_widx[0]  = ld_idx_i;
  assign rf_wdata[0] = ld_data_i;
  assign rf_rreg[NRD-1] = rd_reg_i;
  assign rf_ridx[NRD-1] = rd_idx_i;
  assign rd_data_o      = rf_rdata[NRD-1];

  // element k of reg r is readable when r is idle or the chained producer has written k
  always_comb begin
    for (int u = 0; u < NU; u++) begin
      rd_ok[u] =
        (!sb[src_a[u]] || (chain_en_i && act[NU-1-u] && dst[NU-1-u] == src_a[u] &&
                           wb_cnt[NU-1-u] > CW'(idx[u]))) &&
        (!sb[src_b[u]] || (chain_en_i && act[NU-1-u] && dst[NU-1-u] == src_b[u] &&
                           wb_cnt[NU-1-u] > CW'(idx[u])));
    end
  end

  generate
    for (genvar u = 0; u < NU; u++) begin : g_unit
      vchain_unit #(
        .ELEM_W(ELEM_W), .VLEN(VLEN), .DEPTH(DEPTH), .NREGS(NREGS),
        .OP(u == 0 ? OP_MUL : OP_ADD)
      ) u_unit (
        .clk_i, .rst_ni,
        .start_i  (start[u]),
        .dst_i    (issue_dst_i),
        .src_a_i  (issue_src_a_i),
        .src_b_i  (issue_src_b_i),
        .rd_ok_i  (rd_ok[u]),
        .opa_i    (rf_rdata[2*u]),
        .opb_i    (rf_rdata[2*u+1]),
        .act_o    (act[u]),
        .dst_o    (dst[u]),
        .src_a_o  (src_a[u]),
        .src_b_o  (src_b[u]),
        .rd_idx_o (idx[u]),
        .fire_o   (fire[u]),
        .wb_en_o  (wb_en[u]),
        .wb_idx_o (wb_idx[u]),
        .wb_data_o(wb_data[u]),
        .wb_cnt_o (wb_cnt[u]),
        .last_o   (last[u])
      );
      assign rf_rreg[2*u]   = src_a[u];
      assign rf_rreg[2*u+1] = src_b[u];
      assign rf_ridx[2*u]   = idx[u];
      assign rf_ridx[2*u+1] = idx[u];
      assign rf_we[u+1]     = wb_en[u];
      assign rf_wreg[u+1]   = dst[u];
      assign rf_widx[u+1]   = wb_idx[u];
      assign rf_wdata[u+1]  = wb_data[u];
    end
  endgenerate

  vchain_rf #(
    .ELEM_W(ELEM_W), .NREGS(NREGS), .VLEN(VLEN), .NRD(NRD), .NWR(NWR)
  ) u_rf (
    .clk_i,
    .we_i   (rf_we),
    .wreg_i (rf_wreg),
    .widx_i (rf_widx),
    .wdata_i(rf_wdata),
    .rreg_i (rf_rreg),
    .ridx_i (rf_ridx),
    .rdata_o(rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sb     <= '0;
      done_o <= 1'b0;
    end else begin
      for (int u = 0; u < NU; u++) begin
        if (last[u]) sb[dst[u]] <= 1'b0;
      end
      if (accept) sb[issue_dst_i] <= 1'b1;
      done_o <= (|last) && !(|(act & ~last)) && !accept;
    end
  end
endmodule

// File: rtl/vchain_chk.sv
module vchain_chk #(
  parameter int NREGS = 8,
  parameter int VLEN  = 64
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            done_o,
  input logic                            issue_valid_i,
  input logic                            issue_op_i,
  input logic                            issue_ready_o,
  input logic [1:0]                      act_i,
  input logic [1:0]                      last_i,
  input logic [1:0]                      fire_i,
  input logic [1:0][$clog2(NREGS)-1:0]   dst_i,
  input logic [1:0][$clog2(NREGS)-1:0]   src_a_i,
  input logic [1:0][$clog2(NREGS)-1:0]   src_b_i,
  input logic [1:0][$clog2(VLEN)-1:0]    idx_i,
  input logic [1:0][$clog2(VLEN+1)-1:0]  wb_cnt_i
);
  localparam int CW = $clog2(VLEN+1);

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> act_i == 2'b00);

  // R8
  add_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_i[1]) |-> $past(issue_valid_i && issue_ready_o && issue_op_i));

  // R8
  mul_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(act_i[0]) |-> $past(issue_valid_i && issue_ready_o && !issue_op_i));

  // R9
  mul_to_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i[1] && act_i[0] && (src_a_i[1] == dst_i[0] || src_b_i[1] == dst_i[0]))
      |-> wb_cnt_i[0] > CW'(idx_i[1]));

  // R9
  add_to_mul_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i[0] && act_i[1] && (src_a_i[0] == dst_i[1] || src_b_i[0] == dst_i[1]))
      |-> wb_cnt_i[1] > CW'(idx_i[0]));

  // R3
  last_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i[0] |-> wb_cnt_i[0] == CW'(VLEN-1));
endmodule

bind vchain_top vchain_chk #(.NREGS(NREGS), .VLEN(VLEN)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .done_o       (done_o),
  .issue_valid_i(issue_valid_i),
  .issue_op_i   (issue_op_i),
  .issue_ready_o(issue_ready_o),
  .act_i        (act),
  .last_i       (last),
  .fire_i       (fire),
  .dst_i        (dst),
  .src_a_i      (src_a),
  .src_b_i      (src_b),
  .idx_i        (idx),
  .wb_cnt_i     (wb_cnt)
);

// File: tb/sim_vchain_top.sv
module sim_vchain_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        chain_en, ld_en, iv, iop, ready, done;
  logic [2:0]  ld_reg, rd_reg, idst, isa, isb;
  logic [5:0]  ld_idx, rd_idx;
  logic [15:0] ld_data, rd_data;
  logic [15:0] mdl [8][64];
  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  vchain_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .chain_en_i(chain_en),
    .ld_en_i(ld_en), .ld_reg_i(ld_reg), .ld_idx_i(ld_idx), .ld_data_i(ld_data),
    .rd_reg_i(rd_reg), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .issue_valid_i(iv), .issue_op_i(iop), .issue_dst_i(idst),
    .issue_src_a_i(isa), .issue_src_b_i(isb),
    .issue_ready_o(ready), .done_o(done)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_reg(int r);
    for (int k = 0; k < 64; k++) begin
      ld_en = 1'b1; ld_reg = 3'(r); ld_idx = 6'(k);
      ld_data = 16'(r * 4099 + k * 1237 + 301);
      mdl[r][k] = ld_data;
      @(posedge clk); @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic check_reg(int r, string req);
    for (int k = 0; k < 64; k++) begin
      rd_reg = 3'(r); rd_idx = 6'(k); #1;
      chk(rd_data == mdl[r][k], req, rd_data, mdl[r][k]);
    end
  endtask

  // model update: op 0 multiply, 1 add, low 16 bits kept
  task automatic model_op(bit op, int d, int a, int b);
    for (int k = 0; k < 64; k++)
      mdl[d][k] = op ? 16'(mdl[a][k] + mdl[b][k]) : 16'(mdl[a][k] * mdl[b][k]);
  endtask

  // at a negedge: drive one issue, pass its accept edge, drop valid
  task automatic put(bit op, int d, int a, int b);
    iv = 1'b1; iop = op; idst = 3'(d); isa = 3'(a); isb = 3'(b);
    @(posedge clk); @(negedge clk);
    iv = 1'b0;
  endtask

  // reference timing: done_o high only at edge exp_done after the first accept
  task automatic watch(int from_c, int exp_done, string req, bit probe, int old0, int new0);
    for (int c = from_c + 1; c <= exp_done + 3; c++) begin
      @(posedge clk); @(negedge clk);
      chk(done == (c == exp_done), req, done, int'(c == exp_done));
      if (probe) chk(rd_data == 16'(c >= 6 ? new0 : old0), "R3 element 0 writeback",
                     rd_data, c >= 6 ? new0 : old0);
    end
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int old0, new0;
    rst_n = 1'b0; chain_en = 1'b0; ld_en = 1'b0; iv = 1'b0; iop = 1'b0;
    ld_reg = '0; ld_idx = '0; ld_data = '0; rd_reg = '0; rd_idx = '0;
    idst = '0; isa = '0; isb = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", done, 0);
    rst_n = 1'b1;
    #1;
    chk(done == 1'b0, "R1 done idle", done, 0);
    chk(ready == 1'b1, "R1 ready idle", ready, 1);

    for (int r = 0; r < 8; r++) load_reg(r);

    // R2 R3: isolated multiply r4 = r1 * r2 with element-0 probe
    chain_en = 1'b1;
    rd_reg = 3'd4; rd_idx = 6'd0;
    old0 = mdl[4][0];
    new0 = 16'(mdl[1][0] * mdl[2][0]);
    put(1'b0, 4, 1, 2);
    watch(0, 69, "R3 single multiply done", 1'b1, old0, new0);
    model_op(1'b0, 4, 1, 2);
    check_reg(4, "R2 multiply result");

    // R2 R3: isolated add r5 = r4 + r3
    put(1'b1, 5, 4, 3);
    watch(0, 69, "R3 single add done", 1'b0, 0, 0);
    model_op(1'b1, 5, 4, 3);
    check_reg(5, "R2 add result");

    // R4: unchained dependent pair r6 = r1*r2 ; r7 = r6 + r3
    chain_en = 1'b0;
    put(1'b0, 6, 1, 2);
    put(1'b1, 7, 6, 3);
    watch(1, 138, "R4 unchained done", 1'b0, 0, 0);
    model_op(1'b0, 6, 1, 2);
    model_op(1'b1, 7, 6, 3);
    check_reg(6, "R4 unchained product");
    check_reg(7, "R4 unchained sum");

    // R5 R6 R8: chained pair r6 = r3*r1 ; r7 = r2 + r6, busy probes first
    chain_en = 1'b1;
    put(1'b0, 6, 3, 1);
    iop = 1'b0; idst = 3'd0; #1;
    chk(ready == 1'b0, "R8 multiply unit busy", ready, 0);
    iop = 1'b1; idst = 3'd6; #1;
    chk(ready == 1'b0, "R8 destination busy", ready, 0);
    put(1'b1, 7, 2, 6);
    watch(1, 75, "R5 chained done", 1'b0, 0, 0);
    model_op(1'b0, 6, 3, 1);
    model_op(1'b1, 7, 2, 6);
    check_reg(6, "R6 chained product");
    check_reg(7, "R6 chained sum");
    check_reg(0, "R8 rejected issue left r0 intact");

    // R10 R7: independent mul and add, single done at edge 70
    put(1'b0, 0, 1, 2);
    put(1'b1, 5, 1, 3);
    watch(1, 70, "R10 R7 concurrent done", 1'b0, 0, 0);
    model_op(1'b0, 0, 1, 2);
    model_op(1'b1, 5, 1, 3);
    check_reg(0, "R10 concurrent product");
    check_reg(5, "R10 concurrent sum");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule